// File: doc/BRIEF.md
# Bit-Banged Serial EEPROM Responder

This block stands in for a small serial EEPROM of 16-bit words. Software owns the serial clock and the serial input: it writes one 32-bit control word, and the block acts only when a write moves the clock bit from 0 to 1. Each such edge moves a command sequencer one step forward. The sequencer first collects an 8-bit command. For a word read it then collects an 8-bit word address and returns the addressed word one bit per edge, least significant bit first, on a read-only output bit of the same control word. For a status read it returns eight zero bits, with no address phase.

The storage holds one fixed nonzero word: word 0 reads 0xBABA and every other word reads zero. The block also answers an ownership handshake. On every write, the grant bit copies the request bit that was just written. An unknown command, an address past the storage depth, or an edge that fits no phase raises a sticky error. The error freezes the sequencer until reset.

Top module: `seeprom_resp`

## Requirements
- R1: After reset, the control word reads 0x0000_0060 (only the write-enable bit 5 and the type bit 6 are set) and the error output is 0.
- R2: The sequencer advances only on a write that sets bit 0 (clock) while the stored clock bit is 0. A write that keeps the clock at 1, or that lowers it, changes neither the sequence nor the output bit.
- R3: The first 8 edges shift bit 1 (serial input) into the command, earliest bit most significant. Command 0x03 selects a word read and 0x05 a status read. Any other value sets the error output when its 8th bit arrives.
- R4: For a word read, the next 8 edges shift in the word address, most significant bit first.
- R5: For a word read, the next 16 edges each place one bit of the addressed word on bit 2 (serial output), starting at bit 0. Word 0 holds 0xBABA and every other word holds 0.
- R6: A completed address of 64 or more (the storage depth) sets the error output. Addresses up to 63 do not.
- R7: For a status read, the 8 edges after the command each drive the output bit to 0. During the command phase the output bit keeps its previous value.
- R8: After the 16th bit of a word read, or the 8th bit of a status read, the sequencer returns to the command phase, so a new command can follow at once.
- R9: Every write copies the written request bit (bit 3) into the grant bit (bit 4).
- R10: Once the error output is set it stays set until reset, and later edges leave the output bit unchanged.
- R11: Bits 0, 1, 3, 5 and 6 read back as last written. Bit 2 ignores the written value. Bits 31..7 read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 32 | Value written to the control word |
| rd_data | output | 32 | Current control word |
| err | output | 1 | Sticky protocol error |

## Verification
The bench builds the block with its default parameters: 8-bit addresses, 64 words, 16-bit words and 8 status bits. The address field is wider than the storage, so addresses 63 (last valid) and 64 (first invalid) can both be driven through the normal serial protocol. Because 0xBABA mixes ones and zeros, every data bit in a read has a distinct expected value. Reading word 0 just before a status read leaves the output bit at 1, so the forced zeros of the status read are visible.

// File: rtl/seeprom_resp.sv
module seeprom_resp #(
  parameter int OP_BITS   = 8,
  parameter int ADDR_BITS = 8,
  parameter int WORD_BITS = 16,
  parameter int STAT_BITS = 8,
  parameter int DEPTH     = 64,
  parameter logic [OP_BITS-1:0]   CMD_READ = 8'h03,
  parameter logic [OP_BITS-1:0]   CMD_STAT = 8'h05,
  parameter logic [WORD_BITS-1:0] WORD0    = 16'hBABA
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [31:0] wr_data,
  output logic [31:0] rd_data,
  output logic        err
);
  localparam int B_SCK = 0, B_DIN = 1, B_DOUT = 2, B_REQ = 3, B_GNT = 4, B_WEN = 5, B_TYP = 6;
  localparam int OCW = $clog2(OP_BITS + 1);
  localparam int ACW = $clog2(ADDR_BITS + 1);
  localparam int DCW = $clog2(WORD_BITS + 1);
  localparam int DIW = $clog2(WORD_BITS);
  localparam logic [OCW-1:0] OP_DONE   = OCW'(OP_BITS);
  localparam logic [OCW-1:0] OP_LAST   = OCW'(OP_BITS - 1);
  localparam logic [ACW-1:0] AD_DONE   = ACW'(ADDR_BITS);
  localparam logic [ACW-1:0] AD_LAST   = ACW'(ADDR_BITS - 1);
  localparam logic [DCW-1:0] WD_DONE   = DCW'(WORD_BITS);
  localparam logic [DCW-1:0] WD_LAST   = DCW'(WORD_BITS - 1);
  localparam logic [DCW-1:0] ST_DONE   = DCW'(STAT_BITS);
  localparam logic [DCW-1:0] ST_LAST   = DCW'(STAT_BITS - 1);
  localparam logic [ADDR_BITS:0] DEPTH_W = (ADDR_BITS+1)'(DEPTH);

  logic sck_q, din_q, dout_q, req_q, gnt_q, wen_q, typ_q, err_q;
  logic [OP_BITS-1:0]   opcode;
  logic [ADDR_BITS-1:0] addr;
  logic [OCW-1:0]       op_cnt;
  logic [ACW-1:0]       ad_cnt;
  logic [DCW-1:0]       dt_cnt;

  wire                 rise    = wr_en && wr_data[B_SCK] && !sck_q;
  wire                 din_w   = wr_data[B_DIN];
  wire [OP_BITS-1:0]   op_nx   = {opcode[OP_BITS-2:0], din_w};
  wire [ADDR_BITS-1:0] ad_nx   = {addr[ADDR_BITS-2:0], din_w};
  wire                 is_rd   = opcode == CMD_READ;
  wire                 is_st   = opcode == CMD_STAT;
  wire [WORD_BITS-1:0] word    = (addr == '0) ? WORD0 : '0;
  wire                 unused_wr = ^{wr_data[31:7], wr_data[B_DOUT], wr_data[B_GNT]};

  assign rd_data = {25'd0, typ_q, wen_q, gnt_q, req_q, dout_q, din_q, sck_q};
  assign err     = err_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sck_q <= 1'b0; din_q <= 1'b0; dout_q <= 1'b0; req_q <= 1'b0; gnt_q <= 1'b0;
      wen_q <= 1'b1; typ_q <= 1'b1; err_q <= 1'b0;
      opcode <= '0; addr <= '0; op_cnt <= '0; ad_cnt <= '0; dt_cnt <= '0;
    end else begin
      if (wr_en) begin
        sck_q <= wr_data[B_SCK];
        din_q <= wr_data[B_DIN];
        req_q <= wr_data[B_REQ];
        gnt_q <= wr_data[B_REQ];
        wen_q <= wr_data[B_WEN];
        typ_q <= wr_data[B_TYP];
      end
      if (rise && !err_q) begin
        if (op_cnt != OP_DONE) begin
          opcode <= op_nx;
          op_cnt <= op_cnt + 1'b1;
          if (op_cnt == OP_LAST && op_nx != CMD_READ && op_nx != CMD_STAT)
            err_q <= 1'b1;
        end else if (is_rd && ad_cnt != AD_DONE) begin
          addr   <= ad_nx;
          ad_cnt <= ad_cnt + 1'b1;
          if (ad_cnt == AD_LAST && {1'b0, ad_nx} >= DEPTH_W)
            err_q <= 1'b1;
        end else if (is_rd && dt_cnt != WD_DONE) begin
          dout_q <= word[dt_cnt[DIW-1:0]];
          if (dt_cnt == WD_LAST) begin
            opcode <= '0; addr <= '0; op_cnt <= '0; ad_cnt <= '0; dt_cnt <= '0;
          end else
            dt_cnt <= dt_cnt + 1'b1;
        end else if (is_st && dt_cnt != ST_DONE) begin
          dout_q <= 1'b0;
          if (dt_cnt == ST_LAST) begin
            opcode <= '0; addr <= '0; op_cnt <= '0; ad_cnt <= '0; dt_cnt <= '0;
          end else
            dt_cnt <= dt_cnt + 1'b1;
        end else
          err_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/seeprom_resp_chk.sv
module seeprom_resp_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic [31:0] wr_data,
  input logic [31:0] rd_data,
  input logic        err
);
  a_r2_no_edge_no_shift: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !(wr_data[0] && !rd_data[0])) |=> $stable(rd_data[2]));

  a_r9_grant_tracks_req: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (rd_data[4] == $past(wr_data[3])));

  a_r10_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err);

  a_r10_frozen_output: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> $stable(rd_data[2]));

  a_r11_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ($stable(rd_data) && $stable(err)));
endmodule

bind seeprom_resp seeprom_resp_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
  .rd_data(rd_data), .err(err)
);

// File: tb/seeprom_resp_test.sv
module seeprom_resp_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        err;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  seeprom_resp uut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
                    .rd_data(rd_data), .err(err));

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0; wr_en = 1'b0;
    @(negedge clk); @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic do_write(input logic [31:0] v);
    @(negedge clk); wr_en = 1'b1; wr_data = v;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic bit_edge(input logic b);
    do_write({30'd0, b, 1'b0});
    do_write({30'd0, b, 1'b1});
  endtask

  task automatic send_byte(input logic [7:0] v);
    for (int i = 7; i >= 0; i--) bit_edge(v[i]);
  endtask

  task automatic read_word(input logic [7:0] a, output logic [15:0] w);
    send_byte(8'h03);
    send_byte(a);
    for (int i = 0; i < 16; i++) begin
      bit_edge(1'b0);
      w[i] = rd_data[2];
    end
  endtask

  task automatic t_reset();
    check(rd_data == 32'h60, "R1 reset word", rd_data, 32'h60);
    check(err == 1'b0, "R1 reset err", {31'd0, err}, 0);
  endtask

  task automatic t_reads();
    logic [15:0] w;
    read_word(8'd0, w);
    check(w == 16'hBABA, "R3 R4 R5 word0", {16'd0, w}, 32'hBABA);
    read_word(8'd5, w);
    check(w == 16'h0, "R5 word5", {16'd0, w}, 0);
    read_word(8'd63, w);
    check(w == 16'h0, "R6 word63", {16'd0, w}, 0);
    check(err == 1'b0, "R6 no err at 63", {31'd0, err}, 0);
    read_word(8'd0, w);
    check(w == 16'hBABA, "R8 back to back", {16'd0, w}, 32'hBABA);
  endtask

  task automatic t_status();
    logic [15:0] w;
    read_word(8'd0, w);
    check(rd_data[2] == 1'b1, "R7 dout primed", {31'd0, rd_data[2]}, 1);
    send_byte(8'h05);
    check(rd_data[2] == 1'b1, "R7 hold in command", {31'd0, rd_data[2]}, 1);
    for (int i = 0; i < 8; i++) begin
      bit_edge(1'b1);
      check(rd_data[2] == 1'b0, "R7 status bit", {31'd0, rd_data[2]}, 0);
    end
    read_word(8'd0, w);
    check(w == 16'hBABA, "R8 after status", {16'd0, w}, 32'hBABA);
  endtask

  task automatic t_no_advance();
    logic [15:0] w;
    send_byte(8'h03);
    for (int i = 0; i < 8; i++) begin
      bit_edge(1'b0);
      do_write(32'h3);
      do_write(32'h2);
    end
    for (int i = 0; i < 16; i++) begin
      bit_edge(1'b0);
      w[i] = rd_data[2];
      do_write(32'h3);
      check(rd_data[2] == w[i], "R2 high write no shift", {31'd0, rd_data[2]}, {31'd0, w[i]});
    end
    check(w == 16'hBABA, "R2 junk writes ignored", {16'd0, w}, 32'hBABA);
  endtask

  task automatic t_fields();
    do_reset();
    do_write(32'h0000_0008);
    check(rd_data[4:3] == 2'b11, "R9 grant set", {30'd0, rd_data[4:3]}, 3);
    do_write(32'h0);
    check(rd_data[4:3] == 2'b00, "R9 grant clear", {30'd0, rd_data[4:3]}, 0);
    do_write(32'hFFFF_FFFF);
    check(rd_data == 32'h7B, "R11 field readback", rd_data, 32'h7B);
    do_write(32'h0000_0004);
    check(rd_data == 32'h0, "R11 dout not writable", rd_data, 0);
    do_reset();
  endtask

  task automatic t_bad_op();
    logic [15:0] w;
    read_word(8'd0, w);
    send_byte(8'h07);
    check(err == 1'b1, "R3 bad command err", {31'd0, err}, 1);
    for (int i = 0; i < 10; i++) bit_edge(1'b0);
    check(err == 1'b1, "R10 err sticky", {31'd0, err}, 1);
    check(rd_data[2] == 1'b1, "R10 dout frozen", {31'd0, rd_data[2]}, 1);
    do_reset();
    check(err == 1'b0, "R10 cleared by reset", {31'd0, err}, 0);
  endtask

  task automatic t_bad_addr();
    send_byte(8'h03);
    for (int i = 7; i > 0; i--) bit_edge(i == 1 ? 1'b0 : (i == 7 ? 1'b0 : (i == 6 ? 1'b1 : 1'b0)));
    check(err == 1'b0, "R6 no err before last bit", {31'd0, err}, 0);
    bit_edge(1'b0);
    check(err == 1'b1, "R6 addr 64 err", {31'd0, err}, 1);
    for (int i = 0; i < 16; i++) bit_edge(1'b0);
    check(rd_data[2] == 1'b0, "R10 no data after err", {31'd0, rd_data[2]}, 0);
    do_reset();
  endtask

  initial begin
    do_reset();
    t_reset();
    t_reads();
    t_status();
    t_no_advance();
    t_fields();
    t_bad_op();
    t_bad_addr();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule